// File: doc/BRIEF.md
# SD Command Line Frame Monitor

This block listens, without driving anything, to the single-wire command channel of an SD card interface. It samples the line on each rising edge of the card clock, finds the start of every frame, works out from the direction bit whether the host or the card is talking, and collects the index, the body and the seven-bit check code. When the stop bit arrives it publishes the decoded fields with a one-cycle strobe, together with two flags: whether the recomputed check code matched, and whether the stop bit was wrong.

The monitor also tracks the session settings that the data-path monitors next to it need. These are the length of the next card reply (short 48-bit or long 136-bit), the data bus width (one or four lanes), and whether a block transfer is pending and in which direction. All of these are derived only from host commands that arrive intact.

Top module: `cmdline_monitor`

## Requirements
- R1: While the line samples high and no frame is in progress, nothing starts; the first low sample starts a frame on the next cycle.
- R2: The bit after the start bit classifies the frame: 1 means a host command (`frame_is_cmd`=1), 0 means a card reply. Host commands always use the short layout.
- R3: A short frame is start bit, direction, 6-bit index (MSB first), 32-bit body (MSB first), 7-bit check code, stop bit. `frame_done` pulses for exactly one cycle, in the cycle after the stop bit is sampled. The index lands in `frame_index`, the body in `frame_body[31:0]` with upper bits zero, and all reported fields hold until the next completion.
- R4: The check code uses the polynomial x^7+x^3+1 with the register starting at zero. For short frames it covers direction, index and body, 39 bits in line order. `crc_ok` is 1 only when the code matches the received one.
- R5: A stop bit of 0 sets `end_fail`, and 1 clears it. In both cases the monitor hunts for a new start bit immediately, so a frame that follows at once is decoded.
- R6: After an intact command with index 2, 9 or 10, `next_resp_long`=1 and the next card reply is read as long. A long reply is start, direction, 6-bit index, 120-bit payload into `frame_body`, 7-bit check code computed over the payload alone, and stop bit, 136 bits in all, with `frame_long`=1. Any other intact command clears `next_resp_long`.
- R7: An intact command 17 or 18 sets `xfer_pending`=1 and `xfer_read`=1. Command 24 or 25 sets `xfer_pending`=1 and `xfer_read`=0. Command 12 clears `xfer_pending` and leaves `xfer_read`. Other commands leave both unchanged.
- R8: Index 6 is taken as a bus-width command only when the command just before it was index 55. Body bits [1:0]=2'b10 set `bus_wide`=1 (four lanes), 2'b00 set it to 0 (one lane), and other values leave it. Index 6 without a preceding 55 changes nothing.
- R9: Session outputs change only on host commands with `crc_ok`=1 and a good stop bit. Card replies and damaged commands leave them untouched.
- R10: After reset `frame_done`=0, `bus_wide`=0, `next_resp_long`=0 and `xfer_pending`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_line | input | 1 | Sampled command wire, idle high |
| frame_done | output | 1 | One-cycle strobe when a frame has completed |
| frame_is_cmd | output | 1 | Last frame came from the host |
| frame_long | output | 1 | Last frame used the 136-bit layout |
| frame_index | output | 6 | Index field of the last frame |
| frame_body | output | 120 | Body of the last frame (short frames in bits [31:0]) |
| frame_crc | output | 7 | Check code received in the last frame |
| crc_ok | output | 1 | Recomputed check code matched |
| end_fail | output | 1 | Stop bit of the last frame was 0 |
| next_resp_long | output | 1 | Next card reply is expected in long form |
| bus_wide | output | 1 | Data bus in four-lane mode |
| xfer_pending | output | 1 | A block data transfer is expected |
| xfer_read | output | 1 | Expected transfer is card-to-host |

## Verification
On every cycle the assertions check the hunting behaviour at the start bit, the single-cycle strobe, the return to hunting at frame end, that the reported fields hold between completions, and that the session outputs and bus width move only on an intact host command of the right kind. Only the bench scenarios can show that the check code is computed correctly, that exact index, body and width values are decoded, and that sequences such as 55 followed by 6 (or 55, then another command, then 6) leave the expected settings. The same goes for switching to the long reply layout after commands 2, 9 and 10.

// File: rtl/cmdmon_pkg.sv
package cmdmon_pkg;

  localparam int CHK_W = 7;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DIR,
    ST_INDEX,
    ST_BODY,
    ST_CHK,
    ST_STOP
  } fstate_e;

  // One serial step of the x^7 + x^3 + 1 check code, MSB-first input.
  function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CHK_W-1];
    return {c[5], c[4], c[3], c[2] ^ fb, c[1], c[0], fb};
  endfunction

  // Host commands whose reply uses the long layout.
  function automatic logic cmd_wants_long(input logic [5:0] idx);
    return (idx == 6'd2) || (idx == 6'd9) || (idx == 6'd10);
  endfunction

  function automatic logic cmd_is_rd(input logic [5:0] idx);
    return (idx == 6'd17) || (idx == 6'd18);
  endfunction

  function automatic logic cmd_is_wr(input logic [5:0] idx);
    return (idx == 6'd24) || (idx == 6'd25);
  endfunction

endpackage

// File: rtl/cmdmon_chk7.sv
module cmdmon_chk7
  import cmdmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CHK_W-1:0] code
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      code <= '0;
    end else if (en) begin
      code <= chk_step(code, bit_in);
    end
  end

endmodule

// File: rtl/cmdmon_framer.sv
module cmdmon_framer
  import cmdmon_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int LONG_W = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              long_next,
  output logic              active,
  output logic              stop_evt,
  output logic              chk_clr,
  output logic              chk_en,
  output logic              dir_q,
  output logic              long_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [LONG_W-1:0] body_q,
  output logic [CHK_W-1:0]  chk_rx_q
);

  localparam int CNT_W = $clog2(LONG_W);

  fstate_e          st;
  logic [CNT_W-1:0] cnt;
  logic             long_now;

  assign long_now = !line && long_next;
  assign active   = (st != ST_HUNT);
  assign stop_evt = (st == ST_STOP);
  assign chk_clr  = (st == ST_HUNT);

  always_comb begin
    case (st)
      ST_DIR:   chk_en = !long_now;
      ST_INDEX: chk_en = !long_q;
      ST_BODY:  chk_en = 1'b1;
      default:  chk_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      cnt      <= '0;
      dir_q    <= 1'b0;
      long_q   <= 1'b0;
      idx_q    <= '0;
      body_q   <= '0;
      chk_rx_q <= '0;
    end else begin
      case (st)
        ST_HUNT: begin
          if (!line) st <= ST_DIR;
        end
        ST_DIR: begin
          dir_q  <= line;
          long_q <= long_now;
          body_q <= '0;
          cnt    <= CNT_W'(IDX_W - 1);
          st     <= ST_INDEX;
        end
        ST_INDEX: begin
          idx_q <= {idx_q[IDX_W-2:0], line};
          if (cnt == '0) begin
            cnt <= long_q ? CNT_W'(LONG_W - 1) : CNT_W'(ARG_W - 1);
            st  <= ST_BODY;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BODY: begin
          body_q <= {body_q[LONG_W-2:0], line};
          if (cnt == '0) begin
            cnt <= CNT_W'(CHK_W - 1);
            st  <= ST_CHK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CHK: begin
          chk_rx_q <= {chk_rx_q[CHK_W-2:0], line};
          if (cnt == '0) st <= ST_STOP;
          else cnt <= cnt - 1'b1;
        end
        ST_STOP: st <= ST_HUNT;
        default: st <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/cmdmon_session.sv
module cmdmon_session
  import cmdmon_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             good_cmd,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       arg_lo,
  output logic             resp_long,
  output logic             wide,
  output logic             xfer,
  output logic             xfer_rd
);

  logic app_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_long <= 1'b0;
      wide      <= 1'b0;
      xfer      <= 1'b0;
      xfer_rd   <= 1'b0;
      app_pend  <= 1'b0;
    end else if (good_cmd) begin
      resp_long <= cmd_wants_long(idx);
      app_pend  <= (idx == IDX_W'(55));
      if (app_pend && idx == IDX_W'(6)) begin
        if (arg_lo == 2'b10) wide <= 1'b1;
        else if (arg_lo == 2'b00) wide <= 1'b0;
      end
      if (cmd_is_rd(idx)) begin
        xfer    <= 1'b1;
        xfer_rd <= 1'b1;
      end else if (cmd_is_wr(idx)) begin
        xfer    <= 1'b1;
        xfer_rd <= 1'b0;
      end else if (idx == IDX_W'(12)) begin
        xfer <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmdline_monitor.sv
module cmdline_monitor
  import cmdmon_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int LONG_W = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_line,
  output logic              frame_done,
  output logic              frame_is_cmd,
  output logic              frame_long,
  output logic [IDX_W-1:0]  frame_index,
  output logic [LONG_W-1:0] frame_body,
  output logic [CHK_W-1:0]  frame_crc,
  output logic              crc_ok,
  output logic              end_fail,
  output logic              next_resp_long,
  output logic              bus_wide,
  output logic              xfer_pending,
  output logic              xfer_read
);

  // Internal events brought out by name for the checker.
  logic              frame_active;
  logic              stop_evt;
  logic              chk_clr;
  logic              chk_en;
  logic              dir_q;
  logic              long_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LONG_W-1:0] body_q;
  logic [CHK_W-1:0]  chk_rx_q;
  logic [CHK_W-1:0]  chk_calc;
  logic              chk_match;
  logic              good_cmd;

  cmdmon_framer #(.IDX_W(IDX_W), .ARG_W(ARG_W), .LONG_W(LONG_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (cmd_line),
    .long_next (next_resp_long),
    .active    (frame_active),
    .stop_evt  (stop_evt),
    .chk_clr   (chk_clr),
    .chk_en    (chk_en),
    .dir_q     (dir_q),
    .long_q    (long_q),
    .idx_q     (idx_q),
    .body_q    (body_q),
    .chk_rx_q  (chk_rx_q)
  );

  cmdmon_chk7 u_chk7 (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (chk_clr),
    .en     (chk_en),
    .bit_in (cmd_line),
    .code   (chk_calc)
  );

  assign chk_match = (chk_calc == chk_rx_q);
  assign good_cmd  = stop_evt && dir_q && chk_match && cmd_line;

  cmdmon_session #(.IDX_W(IDX_W)) u_session (
    .clk       (clk),
    .rst_n     (rst_n),
    .good_cmd  (good_cmd),
    .idx       (idx_q),
    .arg_lo    (body_q[1:0]),
    .resp_long (next_resp_long),
    .wide      (bus_wide),
    .xfer      (xfer_pending),
    .xfer_rd   (xfer_read)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_done   <= 1'b0;
      frame_is_cmd <= 1'b0;
      frame_long   <= 1'b0;
      frame_index  <= '0;
      frame_body   <= '0;
      frame_crc    <= '0;
      crc_ok       <= 1'b0;
      end_fail     <= 1'b0;
    end else begin
      frame_done <= stop_evt;
      if (stop_evt) begin
        frame_is_cmd <= dir_q;
        frame_long   <= long_q;
        frame_index  <= idx_q;
        frame_body   <= body_q;
        frame_crc    <= chk_rx_q;
        crc_ok       <= chk_match;
        end_fail     <= !cmd_line;
      end
    end
  end

endmodule

// File: rtl/cmdmon_checker.sv
module cmdmon_checker #(
  parameter int IDX_W  = 6,
  parameter int LONG_W = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_line,
  input logic              frame_active,
  input logic              frame_done,
  input logic              frame_is_cmd,
  input logic              frame_long,
  input logic [IDX_W-1:0]  frame_index,
  input logic [LONG_W-1:0] frame_body,
  input logic              crc_ok,
  input logic              end_fail,
  input logic              next_resp_long,
  input logic              bus_wide,
  input logic              xfer_pending
);

  a_r1_stay_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && cmd_line) |=> !frame_active);

  a_r1_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !cmd_line) |=> frame_active);

  a_r2_cmd_is_short: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_is_cmd) |-> !frame_long);

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(frame_index) && $stable(frame_body) &&
                     $stable(crc_ok) && $stable(end_fail)));

  a_r5_back_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_active);

  a_r6_long_only_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_long) |-> (!frame_is_cmd && next_resp_long));

  a_r8_width_on_six: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_wide) |-> (frame_done && frame_is_cmd && frame_index == IDX_W'(6)));

  a_r9_session_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_is_cmd && crc_ok && !end_fail) |->
      ($stable(next_resp_long) && $stable(bus_wide) && $stable(xfer_pending)));

endmodule

bind cmdline_monitor cmdmon_checker #(.IDX_W(IDX_W), .LONG_W(LONG_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_line       (cmd_line),
  .frame_active   (frame_active),
  .frame_done     (frame_done),
  .frame_is_cmd   (frame_is_cmd),
  .frame_long     (frame_long),
  .frame_index    (frame_index),
  .frame_body     (frame_body),
  .crc_ok         (crc_ok),
  .end_fail       (end_fail),
  .next_resp_long (next_resp_long),
  .bus_wide       (bus_wide),
  .xfer_pending   (xfer_pending)
);

// File: tb/cmdline_monitor_test.sv
module cmdline_monitor_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_line = 1'b1;
  logic         frame_done, frame_is_cmd, frame_long;
  logic [5:0]   frame_index;
  logic [119:0] frame_body;
  logic [6:0]   frame_crc;
  logic         crc_ok, end_fail, next_resp_long, bus_wide, xfer_pending, xfer_read;

  int errs = 0;
  int checks = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  cmdline_monitor uut (
    .clk(clk), .rst_n(rst_n), .cmd_line(cmd_line),
    .frame_done(frame_done), .frame_is_cmd(frame_is_cmd), .frame_long(frame_long),
    .frame_index(frame_index), .frame_body(frame_body), .frame_crc(frame_crc),
    .crc_ok(crc_ok), .end_fail(end_fail), .next_resp_long(next_resp_long),
    .bus_wide(bus_wide), .xfer_pending(xfer_pending), .xfer_read(xfer_read)
  );

  always @(posedge clk) if (rst_n && frame_done) pulses <= pulses + 1;

  // Table: {index, body, exp next_resp_long, exp bus_wide, exp xfer_pending, exp xfer_read}
  localparam logic [41:0] TBL [15] = '{
    {6'd0,  32'h0000_0000, 4'b0000},
    {6'd2,  32'h0000_0000, 4'b1000},
    {6'd3,  32'h0000_0000, 4'b0000},
    {6'd9,  32'hABCD_0000, 4'b1000},
    {6'd55, 32'hABCD_0000, 4'b0000},
    {6'd6,  32'h0000_0002, 4'b0100},
    {6'd17, 32'h0000_0200, 4'b0111},
    {6'd12, 32'h0000_0000, 4'b0101},
    {6'd24, 32'h0000_0400, 4'b0110},
    {6'd6,  32'h0000_0000, 4'b0110},
    {6'd55, 32'h1234_0000, 4'b0110},
    {6'd6,  32'h0000_0003, 4'b0110},
    {6'd55, 32'h1234_0000, 4'b0110},
    {6'd6,  32'h0000_0000, 4'b0010},
    {6'd10, 32'h5A5A_C3C3, 4'b1010}
  };

  function automatic logic [6:0] ref_code(input logic [127:0] v, input int n);
    logic [6:0] r;
    logic top;
    r = 7'd0;
    for (int i = n - 1; i >= 0; i--) begin
      top = r[6] ^ v[i];
      r = {r[5:0], 1'b0};
      if (top) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic dir, input logic [5:0] idx, input logic [119:0] body,
                            input bit lng, input bit bad_code, input bit bad_stop);
    logic [6:0] c;
    int nb;
    nb = lng ? 120 : 32;
    if (lng) c = ref_code({8'd0, body}, 120);
    else     c = ref_code({89'd0, dir, idx, body[31:0]}, 39);
    if (bad_code) c = c ^ 7'h01;
    @(negedge clk) cmd_line = 1'b0;
    @(negedge clk) cmd_line = dir;
    for (int i = 5; i >= 0; i--) begin @(negedge clk) cmd_line = idx[i]; end
    for (int i = nb - 1; i >= 0; i--) begin @(negedge clk) cmd_line = body[i]; end
    for (int i = 6; i >= 0; i--) begin @(negedge clk) cmd_line = c[i]; end
    @(negedge clk) cmd_line = !bad_stop;
    @(posedge clk);
    #1;
    cmd_line = 1'b1;
  endtask

  initial begin
    #1_500_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [119:0] pay;
    logic [5:0]   old_idx;
    int           p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 frame_done", 128'(frame_done), 128'(0));
    chk("R10 bus_wide", 128'(bus_wide), 128'(0));
    chk("R10 next_resp_long", 128'(next_resp_long), 128'(0));
    chk("R10 xfer_pending", 128'(xfer_pending), 128'(0));

    // R1 idle line produces nothing
    p0 = pulses;
    repeat (30) @(negedge clk);
    chk("R1 idle no frame", 128'(pulses - p0), 128'(0));

    // Table walk over host commands: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 15; k++) begin
      send_frame(1'b1, TBL[k][41:36], {88'd0, TBL[k][35:4]}, 1'b0, 1'b0, 1'b0);
      chk("R3 frame_done", 128'(frame_done), 128'(1));
      chk("R2 frame_is_cmd", 128'(frame_is_cmd), 128'(1));
      chk("R3 index", 128'(frame_index), 128'(TBL[k][41:36]));
      chk("R3 body", 128'(frame_body), 128'(TBL[k][35:4]));
      chk("R4 crc_ok", 128'(crc_ok), 128'(1));
      chk("R5 end_fail", 128'(end_fail), 128'(0));
      chk("R6 next_resp_long", 128'(next_resp_long), 128'(TBL[k][3]));
      chk("R8 bus_wide", 128'(bus_wide), 128'(TBL[k][2]));
      chk("R7 xfer_pending", 128'(xfer_pending), 128'(TBL[k][1]));
      chk("R7 xfer_read", 128'(xfer_read), 128'(TBL[k][0]));
      repeat (3) @(negedge clk);
    end

    // R3 strobe is one cycle and fields hold
    old_idx = frame_index;
    chk("R3 strobe low after", 128'(frame_done), 128'(0));
    chk("R3 index held", 128'(frame_index), 128'(old_idx));

    // R6 long reply after index 10; R9 reply keeps session
    pay = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    send_frame(1'b0, 6'h3F, pay, 1'b1, 1'b0, 1'b0);
    chk("R6 frame_long", 128'(frame_long), 128'(1));
    chk("R6 long payload", 128'(frame_body), 128'(pay));
    chk("R6 long crc_ok", 128'(crc_ok), 128'(1));
    chk("R2 reply dir", 128'(frame_is_cmd), 128'(0));
    chk("R9 reply keeps long", 128'(next_resp_long), 128'(1));

    // Short reply after a short-reply command
    send_frame(1'b1, 6'd13, 120'h0000_0000_0000_0000_0000_0000_0001_0000, 1'b0, 1'b0, 1'b0);
    chk("R6 short after 13", 128'(next_resp_long), 128'(0));
    send_frame(1'b0, 6'd13, 120'h900, 1'b0, 1'b0, 1'b0);
    chk("R6 short reply", 128'(frame_long), 128'(0));
    chk("R4 reply crc_ok", 128'(crc_ok), 128'(1));
    chk("R3 reply body", 128'(frame_body), 128'(32'h900));
    chk("R3 crc field", 128'(frame_crc), 128'(ref_code({89'd0, 1'b0, 6'd13, 32'h900}, 39)));

    // R4 damaged code; R9 session untouched
    send_frame(1'b1, 6'd2, 120'd0, 1'b0, 1'b1, 1'b0);
    chk("R4 bad crc flagged", 128'(crc_ok), 128'(0));
    chk("R9 bad crc no long", 128'(next_resp_long), 128'(0));

    // R5 bad stop bit, then an immediate frame is decoded
    send_frame(1'b1, 6'd9, 120'd0, 1'b0, 1'b0, 1'b1);
    chk("R5 end_fail set", 128'(end_fail), 128'(1));
    chk("R9 bad stop no long", 128'(next_resp_long), 128'(0));
    send_frame(1'b1, 6'd0, 120'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 recovered frame", 128'(frame_done), 128'(1));
    chk("R5 end_fail cleared", 128'(end_fail), 128'(0));

    // R8 index 55, then another command, then 6: no width change
    send_frame(1'b1, 6'd55, 120'd0, 1'b0, 1'b0, 1'b0);
    send_frame(1'b1, 6'd13, 120'd0, 1'b0, 1'b0, 1'b0);
    send_frame(1'b1, 6'd6, 120'd2, 1'b0, 1'b0, 1'b0);
    chk("R8 broken prefix", 128'(bus_wide), 128'(0));

    // R9 reply with index 6 after 55 does not set width
    send_frame(1'b1, 6'd55, 120'd0, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 6'd6, 120'd2, 1'b0, 1'b0, 1'b0);
    chk("R9 reply no width", 128'(bus_wide), 128'(0));

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule